// File: doc/BRIEF.md
# Serial Synthesizer Control Register Interface

This block is the three-wire programming port of a frequency synthesizer. A host clocks a 24-bit word in, most significant bit first, using a serial clock and a serial data line. A rising edge on the latch strobe ends the word. The two lowest bits of the word are an address. When the address is zero, the block copies two fields of the word into its F1 register. When the address is anything else, F1 keeps its contents. All three serial lines are brought into the core clock domain through a synchronizer, and their edges are detected there.

The F1 register holds two fields. The first is a single bit that picks the fractional modulus resolution of the divider. The second is a 3-bit code that picks what appears on the shared lock-detect status pin. That pin can show the raw phase-coincidence signal from the phase detector, a filtered digital lock flag, the N divider output or the R divider output. A disallowed code forces the pin low and raises a sticky error flag, which software reads back on its own port.

Top module: `synth_ser_ctl`

## Requirements
- R1: After reset, `frac16` is 0, `ld_err` is 0 and the pin-function code is 000, so `ld_pin` follows `phase_coinc`.
- R2: On each rising edge of `sclk`, the value on `sdat` enters bit 0 of a 24-bit shift register and every older bit moves up one place. The word acted on is therefore the last 24 bits shifted in; earlier bits fall out of the top.
- R3: On a rising edge of `le`, when shift-register bits [1:0] equal 00, F1 takes its modulus bit from shift-register bit 20 and its pin-function code from bits [19:17].
- R4: A rising edge of `le` with an address of 01, 10 or 11 leaves `frac16`, `ld_pin` selection and `ld_err` unchanged.
- R5: Shifting data while `le` stays low changes none of the outputs. A later rising edge of `le` with no further shifting loads the word already held in the shift register.
- R6: `frac16` is 1 (1/16 resolution) when the stored modulus bit is 1, and 0 (1/15 resolution) when it is 0.
- R7: Code 000 makes `ld_pin` follow `phase_coinc`.
- R8: Code 010 makes `ld_pin` follow `dig_lock`.
- R9: Code 110 makes `ld_pin` follow `n_div`, and code 111 makes it follow `r_div`.
- R10: Codes 001, 011, 100 and 101 are reserved. Loading one of them drives `ld_pin` low whatever the four sources are, and sets `ld_err`.
- R11: Once `ld_err` is set, it stays 1 through later valid writes. Only reset clears it.
- R12: Shift-register bits 23:21 and 16:2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdat | input | 1 | Serial data, MSB first |
| le | input | 1 | Latch strobe; its rising edge loads the addressed register |
| phase_coinc | input | 1 | Raw phase-coincidence signal from the phase detector |
| dig_lock | input | 1 | Filtered digital lock flag |
| n_div | input | 1 | N divider output |
| r_div | input | 1 | R divider output |
| frac16 | output | 1 | Fractional modulus select: 1 for 1/16, 0 for 1/15 |
| ld_pin | output | 1 | Lock-detect status pin |
| ld_err | output | 1 | Sticky flag set by a reserved pin-function code |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 2-bit address, F1 at address zero and a two-stage synchronizer. With these values every real code value and every address is reachable. The serial phases the bench drives last several core clocks, so each edge passes through the synchronizer before the bench samples. Words longer than 24 bits, don't-care fields filled with all ones and all zeros, and a latch strobe with no new shifting all exercise the edge-gated loading directly.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    // Pin-function codes stored in F1; all others are reserved.
    localparam logic [2:0] LDSEL_PHASE = 3'b000;
    localparam logic [2:0] LDSEL_DIG   = 3'b010;
    localparam logic [2:0] LDSEL_NDIV  = 3'b110;
    localparam logic [2:0] LDSEL_RDIV  = 3'b111;

    typedef struct packed {
        logic       frac16;
        logic [2:0] ld_sel;
        logic       err;
    } f1_state_t;

    function automatic logic sel_reserved(input logic [2:0] code);
        return !(code == LDSEL_PHASE || code == LDSEL_DIG ||
                 code == LDSEL_NDIV  || code == LDSEL_RDIV);
    endfunction

endpackage

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int SR_W        = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_i,
    input  logic            sdat_i,
    input  logic            le_i,
    output logic [SR_W-1:0] word_o,
    output logic            latch_o
);

    localparam int LINES   = 3;
    localparam int CHAIN_W = LINES * SYNC_STAGES;

    logic [CHAIN_W-1:0] chain_q;
    logic [LINES-1:0]   sync_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {sclk_i, sdat_i, le_i};
            end
        end else begin : g_sync_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CHAIN_W-LINES-1:0], sclk_i, sdat_i, le_i};
            end
        end
    endgenerate

    assign sync_s = chain_q[CHAIN_W-1 -: LINES];

    logic sclk_s, sdat_s, le_s;
    assign sclk_s = sync_s[2];
    assign sdat_s = sync_s[1];
    assign le_s   = sync_s[0];

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            sclk_prev;
        logic            le_prev;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         shift_en;

    always_comb begin
        st_d           = st_q;
        shift_en       = sclk_s & ~st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;
        st_d.le_prev   = le_s;
        if (shift_en) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdat_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.sr;
    assign latch_o = le_s & ~st_q.le_prev;

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (st_q.sr[0] == $past(sdat_s)) &&
                     (st_q.sr[SR_W-1:1] == $past(st_q.sr[SR_W-2:0])));

endmodule

// File: rtl/sctl_f1.sv
module sctl_f1
    import sctl_pkg::*;
#(
    parameter int SR_W     = 24,
    parameter int ADDR_W   = 2,
    parameter int F1_ADDR  = 0,
    parameter int FRAC_BIT = 20,
    parameter int SEL_LSB  = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [SR_W-1:0] word_i,
    output logic            frac16_o,
    output logic [2:0]      ld_sel_o,
    output logic            err_o
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(F1_ADDR);

    f1_state_t  st_d, st_q;
    logic       hit;
    logic [2:0] new_sel;

    always_comb begin
        st_d    = st_q;
        hit     = load_i && (word_i[ADDR_W-1:0] == MY_ADDR);
        new_sel = word_i[SEL_LSB +: 3];
        if (hit) begin
            st_d.frac16 = word_i[FRAC_BIT];
            st_d.ld_sel = new_sel;
            if (sel_reserved(new_sel)) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{frac16: 1'b0, ld_sel: LDSEL_PHASE, err: 1'b0};
        else        st_q <= st_d;
    end

    assign frac16_o = st_q.frac16;
    assign ld_sel_o = st_q.ld_sel;
    assign err_o    = st_q.err;

    // R4
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && word_i[ADDR_W-1:0] != MY_ADDR) |=>
            $stable(st_q.frac16) && $stable(st_q.ld_sel) && $stable(st_q.err));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.frac16) && $stable(st_q.ld_sel));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R10
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && word_i[ADDR_W-1:0] == MY_ADDR && sel_reserved(word_i[SEL_LSB +: 3]))
            |=> st_q.err);

endmodule

// File: rtl/sctl_ldmux.sv
module sctl_ldmux
    import sctl_pkg::*;
(
    input  logic [2:0] sel_i,
    input  logic       phase_i,
    input  logic       dig_i,
    input  logic       ndiv_i,
    input  logic       rdiv_i,
    output logic       pin_o
);

    always_comb begin
        case (sel_i)
            LDSEL_PHASE: pin_o = phase_i;
            LDSEL_DIG:   pin_o = dig_i;
            LDSEL_NDIV:  pin_o = ndiv_i;
            LDSEL_RDIV:  pin_o = rdiv_i;
            default:     pin_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/synth_ser_ctl.sv
module synth_ser_ctl
    import sctl_pkg::*;
#(
    parameter int SR_W        = 24,
    parameter int ADDR_W      = 2,
    parameter int F1_ADDR     = 0,
    parameter int FRAC_BIT    = 20,
    parameter int SEL_LSB     = 17,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sdat,
    input  logic le,
    input  logic phase_coinc,
    input  logic dig_lock,
    input  logic n_div,
    input  logic r_div,
    output logic frac16,
    output logic ld_pin,
    output logic ld_err
);

    logic [SR_W-1:0] word;
    logic            latch;
    logic [2:0]      ld_sel;

    sctl_shift #(.SR_W(SR_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_i(sclk), .sdat_i(sdat), .le_i(le),
        .word_o(word), .latch_o(latch)
    );

    sctl_f1 #(.SR_W(SR_W), .ADDR_W(ADDR_W), .F1_ADDR(F1_ADDR),
              .FRAC_BIT(FRAC_BIT), .SEL_LSB(SEL_LSB)) u_f1 (
        .clk(clk), .rst_n(rst_n),
        .load_i(latch), .word_i(word),
        .frac16_o(frac16), .ld_sel_o(ld_sel), .err_o(ld_err)
    );

    sctl_ldmux u_mux (
        .sel_i(ld_sel),
        .phase_i(phase_coinc), .dig_i(dig_lock),
        .ndiv_i(n_div), .rdiv_i(r_div),
        .pin_o(ld_pin)
    );

    // R10
    rsvd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_reserved(ld_sel) |-> (!ld_pin && ld_err));

    // R9
    ndiv_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == LDSEL_NDIV) |-> (ld_pin == n_div));

    // R8
    dig_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_sel == LDSEL_DIG) |-> (ld_pin == dig_lock));

endmodule

// File: tb/tb_synth_ser_ctl.sv
module tb_synth_ser_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 5;

    logic clk = 0, rst_n = 0;
    logic sclk = 0, sdat = 0, le = 0;
    logic phase_coinc = 0, dig_lock = 0, n_div = 0, r_div = 0;
    logic frac16, ld_pin, ld_err;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_ser_ctl dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdat(sdat), .le(le),
        .phase_coinc(phase_coinc), .dig_lock(dig_lock), .n_div(n_div), .r_div(r_div),
        .frac16(frac16), .ld_pin(ld_pin), .ld_err(ld_err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [23:0] mk(input logic fr, input logic [2:0] sel,
                                       input logic [1:0] addr, input logic fill);
        logic [23:0] w = {24{fill}};
        w[20]    = fr;
        w[19:17] = sel;
        w[1:0]   = addr;
        return w;
    endfunction

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            wait_clk(PHASE);
            sclk = 1;
            wait_clk(PHASE);
            sclk = 0;
        end
        wait_clk(PHASE);
    endtask

    task automatic pulse_le();
        le = 1;
        wait_clk(PHASE);
        le = 0;
        wait_clk(PHASE);
    endtask

    task automatic write_word(input logic [23:0] w);
        shift_bits({8'h0, w}, 24);
        pulse_le();
    endtask

    task automatic set_src(input logic [3:0] v);  // {r, n, dig, phase}
        {r_div, n_div, dig_lock, phase_coinc} = v;
        #1;
    endtask

    // Pin must follow source idx (0 phase,1 dig,2 n,3 r) and ignore the rest.
    task automatic check_follow(input string tag, input int idx);
        logic [3:0] one = 4'b0001 << idx;
        set_src(one);
        check(tag, ld_pin, 1'b1);
        set_src(~one);
        check(tag, ld_pin, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        sclk = 0; sdat = 0; le = 0;
        wait_clk(3);
        rst_n = 1;
        wait_clk(3);
    endtask

    task automatic t_reset();
        check("R1 frac16", frac16, 1'b0);
        check("R1 err", ld_err, 1'b0);
        check_follow("R1 pin", 0);
    endtask

    task automatic t_routes();
        write_word(mk(1'b1, 3'b010, 2'b00, 1'b0));
        check("R3 R6 frac16=1", frac16, 1'b1);
        check_follow("R8 dig", 1);
        write_word(mk(1'b0, 3'b110, 2'b00, 1'b0));
        check("R6 frac16=0", frac16, 1'b0);
        check_follow("R9 ndiv", 2);
        write_word(mk(1'b1, 3'b111, 2'b00, 1'b0));
        check_follow("R9 rdiv", 3);
        write_word(mk(1'b0, 3'b000, 2'b00, 1'b0));
        check_follow("R7 phase", 0);
        check("R3 err clear", ld_err, 1'b0);
    endtask

    task automatic t_addr();
        write_word(mk(1'b1, 3'b010, 2'b00, 1'b0));
        for (int a = 1; a < 4; a++) begin
            write_word(mk(1'b0, 3'b110, 2'(a), 1'b0));
            check("R4 frac16", frac16, 1'b1);
            check_follow("R4 pin", 1);
        end
        write_word(mk(1'b0, 3'b001, 2'b11, 1'b0));
        check("R4 err", ld_err, 1'b0);
        check_follow("R4 pin rsvd", 1);
    endtask

    task automatic t_no_latch();
        write_word(mk(1'b0, 3'b000, 2'b00, 1'b0));
        shift_bits({8'h0, mk(1'b1, 3'b111, 2'b00, 1'b0)}, 24);
        check("R5 frac16", frac16, 1'b0);
        check_follow("R5 pin", 0);
        pulse_le();
        check("R5 late latch frac16", frac16, 1'b1);
        check_follow("R5 late latch pin", 3);
    endtask

    task automatic t_long_word();
        write_word(mk(1'b0, 3'b000, 2'b00, 1'b0));
        // 6 leading bits with pattern of ones; only last 24 count.
        shift_bits({2'b0, 6'b111111, mk(1'b1, 3'b110, 2'b00, 1'b0)}, 30);
        pulse_le();
        check("R2 frac16", frac16, 1'b1);
        check_follow("R2 pin", 2);
    endtask

    task automatic t_dontcare();
        write_word(mk(1'b0, 3'b010, 2'b00, 1'b1));
        check("R12 ones frac16", frac16, 1'b0);
        check_follow("R12 ones pin", 1);
        check("R12 ones err", ld_err, 1'b0);
        write_word(mk(1'b1, 3'b111, 2'b00, 1'b0));
        check("R12 zeros frac16", frac16, 1'b1);
        check_follow("R12 zeros pin", 3);
    endtask

    task automatic t_reserved();
        logic [2:0] codes [4] = '{3'b001, 3'b011, 3'b100, 3'b101};
        for (int k = 0; k < 4; k++) begin
            do_reset();
            write_word(mk(1'b0, codes[k], 2'b00, 1'b0));
            set_src(4'b1111);
            check("R10 pin low", ld_pin, 1'b0);
            check("R10 err set", ld_err, 1'b1);
        end
        write_word(mk(1'b0, 3'b010, 2'b00, 1'b0));
        check("R11 err held", ld_err, 1'b1);
        check_follow("R11 valid after rsvd", 1);
        do_reset();
        check("R11 reset clears", ld_err, 1'b0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_routes();
        t_addr();
        t_no_latch();
        t_long_word();
        t_dontcare();
        t_reserved();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule